// File: doc/BRIEF.md
# Segmentation Status Queue Reporter

This block turns completion events from a cell segmentation engine into status entries and writes them into host-resident status queues. The engine reports, on several parallel lanes, that it has finished transmitting a buffer. Each event names the channel, whether the buffer closes a PDU, whether an error occurred, and the opaque user pointer from the buffer's descriptor. Events that arrive together are held in a small input FIFO and turned into at most one queue write per cycle.

A per-channel table, loaded through a simple write port, maps every channel to one of 32 queues and picks a reporting granularity. In message mode the block writes one entry per finished PDU and returns the user pointer of the PDU's first buffer. In streaming mode it writes one entry per finished buffer and returns that buffer's own pointer. Errors always produce an entry with its own error flag. Each queue has its own write index that wraps at a fixed size, and a phase bit inverts on every wrap so the host can tell fresh entries from stale ones. The block only writes toward the host and never reads back.

Top module: `ssq_reporter`

## Requirements
- R1: Each channel is mapped to one of 32 queues by a config write (`cfg_qsel`, 5 bits). Every entry for that channel is written with `qw_qsel` equal to the mapped queue.
- R2: In message mode (`cfg_stream`=0) a channel produces exactly one entry per PDU, on the buffer with `ev_last`=1. Non-final, error-free buffers produce no write.
- R3: In streaming mode (`cfg_stream`=1) every buffer produces one entry. Its `qw_eop` equals the buffer's `ev_last`.
- R4: In streaming mode `qw_uptr` is the buffer's own `ev_uptr`. In message mode it is the `ev_uptr` of the first buffer of the PDU, meaning the first buffer after reset, after a final buffer, or after an error on that channel. The value is never altered.
- R5: `qw_chan` equals the channel index of the reported event.
- R6: An event with `ev_err`=1 writes an entry at once in either mode, with `qw_err`=1, `qw_done`=0 and `qw_eop`=0. It also ends the PDU in progress on that channel.
- R7: A completion entry has `qw_done`=1 and `qw_err`=0, with `qw_eop`=1 in message mode. No entry has both flags clear.
- R8: Each queue has its own write index, starting at 0. The index rises by one for every entry written to that queue and wraps at 2^QIDX_W (4). `qw_phase` is 1 on the first pass and inverts on each wrap.
- R9: Events are written in arrival order, one per cycle: earlier cycles first, and within a cycle lane 0 before lane 1. An event accepted at edge t is written at edge t+1 if the FIFO was empty.
- R10: During and after reset `qw_valid` is 0. All queues start at index 0 with phase 1, and every channel starts mapped to queue 0 in message mode with no PDU open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 2 | Per-lane event valid |
| ev_chan | input | 8 | Per-lane channel index, 4 bits per lane |
| ev_last | input | 2 | Per-lane: buffer ends its PDU |
| ev_err | input | 2 | Per-lane: error on this buffer |
| ev_uptr | input | 32 | Per-lane user pointer, 16 bits per lane |
| cfg_we | input | 1 | Channel table write strobe |
| cfg_chan | input | 4 | Channel to configure |
| cfg_qsel | input | 5 | Status queue for the channel |
| cfg_stream | input | 1 | 1 = streaming mode, 0 = message mode |
| qw_valid | output | 1 | Queue write strobe |
| qw_qsel | output | 5 | Target queue |
| qw_idx | output | 2 | Slot index inside the queue |
| qw_phase | output | 1 | Lap phase bit of the entry |
| qw_err | output | 1 | Error entry flag |
| qw_done | output | 1 | Completion entry flag |
| qw_eop | output | 1 | Entry closes a PDU |
| qw_chan | output | 4 | Channel index |
| qw_uptr | output | 16 | Opaque user pointer |

## Verification
On every cycle the assertions check that no entry carries both or neither of the error and completion flags, and that a message-mode buffer with no error and no end of PDU is never followed by a write. They also check that writing a queue's last slot inverts that queue's phase, and that the input FIFO never receives more events than it has free slots. Whether the pointer returned for a multi-buffer PDU is the first descriptor's, whether simultaneous events keep lane order, and whether queue mapping and index wrap hold across many channels can only be shown by the bench's scenarios. The bench compares each of these against its behavioural model.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  localparam int CHAN_W  = 4;
  localparam int N_CHAN  = 1 << CHAN_W;
  localparam int UPTR_W  = 16;
  localparam int QSEL_W  = 5;
  localparam int N_QUEUE = 1 << QSEL_W;
  localparam int QIDX_W  = 2;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              last;
    logic              err;
    logic [UPTR_W-1:0] uptr;
  } evt_t;
endpackage

// File: rtl/ssq_evt_fifo.sv
module ssq_evt_fifo
  import ssq_pkg::*;
#(
  parameter int N_LANES = 2,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LANES-1:0] in_valid,
  input  evt_t               in_evt [N_LANES],
  input  logic               pop,
  output logic               out_valid,
  output evt_t               out_evt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  evt_t          mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] n_push;
  logic [AW-1:0] slot [N_LANES];
  logic          pop_ok;

  assign out_valid = (cnt_q != '0);
  assign out_evt   = mem[rd_ptr_q];
  assign pop_ok    = pop & out_valid;

  always_comb begin
    n_push = '0;
    for (int i = 0; i < N_LANES; i++) begin
      slot[i] = wr_ptr_q + AW'(n_push);
      if (in_valid[i]) n_push = n_push + CW'(1);
    end
    wr_ptr_d = wr_ptr_q + AW'(n_push);
    rd_ptr_d = rd_ptr_q + AW'(pop_ok);
    cnt_d    = cnt_q + n_push - CW'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_LANES; i++) begin
      if (in_valid[i]) mem[slot[i]] <= in_evt[i];
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} + {1'b0, n_push} - (CW+1)'(pop_ok)) <= (CW+1)'(DEPTH));
endmodule

// File: rtl/ssq_chan_table.sv
module ssq_chan_table
  import ssq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic [QSEL_W-1:0] cfg_qsel,
  input  logic              cfg_stream,
  input  logic              in_valid,
  input  evt_t              in_evt,
  output logic              emit,
  output logic              emit_stream,
  output logic [QSEL_W-1:0] emit_qsel,
  output logic [UPTR_W-1:0] emit_uptr,
  output logic              emit_err,
  output logic              emit_done,
  output logic              emit_eop
);
  logic [QSEL_W-1:0] qsel_q   [N_CHAN];
  logic              stream_q [N_CHAN];
  logic              busy_q   [N_CHAN];
  logic [UPTR_W-1:0] held_q   [N_CHAN];

  logic [CHAN_W-1:0] ch;
  logic              first;
  logic              ends_unit;
  logic              busy_nxt;
  logic [UPTR_W-1:0] pdu_ptr;

  always_comb begin
    ch          = in_evt.chan;
    first       = !busy_q[ch];
    ends_unit   = in_evt.last | in_evt.err;
    busy_nxt    = !ends_unit;
    pdu_ptr     = first ? in_evt.uptr : held_q[ch];
    emit_stream = stream_q[ch];
    emit_qsel   = qsel_q[ch];
    emit_err    = in_evt.err;
    emit_done   = !in_evt.err;
    if (stream_q[ch]) begin
      emit      = in_valid;
      emit_uptr = in_evt.uptr;
      emit_eop  = in_evt.last & !in_evt.err;
    end else begin
      emit      = in_valid & ends_unit;
      emit_uptr = pdu_ptr;
      emit_eop  = !in_evt.err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CHAN; i++) begin
        qsel_q[i]   <= '0;
        stream_q[i] <= 1'b0;
        busy_q[i]   <= 1'b0;
      end
    end else begin
      if (cfg_we) begin
        qsel_q[cfg_chan]   <= cfg_qsel;
        stream_q[cfg_chan] <= cfg_stream;
      end
      if (in_valid) busy_q[ch] <= busy_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && first) held_q[ch] <= in_evt.uptr;
  end
endmodule

// File: rtl/ssq_qptr.sv
module ssq_qptr
  import ssq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [QSEL_W-1:0] wr_qsel,
  output logic [QIDX_W-1:0] cur_idx,
  output logic              cur_phase
);
  logic [QIDX_W-1:0] idx_q   [N_QUEUE];
  logic              phase_q [N_QUEUE];
  logic [QIDX_W-1:0] idx_nxt;
  logic              phase_nxt;

  always_comb begin
    cur_idx   = idx_q[wr_qsel];
    cur_phase = phase_q[wr_qsel];
    idx_nxt   = cur_idx + QIDX_W'(1);
    phase_nxt = (&cur_idx) ? !cur_phase : cur_phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_QUEUE; i++) begin
        idx_q[i]   <= '0;
        phase_q[i] <= 1'b1;
      end
    end else if (wr_en) begin
      idx_q[wr_qsel]   <= idx_nxt;
      phase_q[wr_qsel] <= phase_nxt;
    end
  end

  // R8
  wrap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&cur_idx)) |=> (phase_q[$past(wr_qsel)] != $past(cur_phase)));
endmodule

// File: rtl/ssq_reporter.sv
module ssq_reporter
  import ssq_pkg::*;
#(
  parameter int N_LANES    = 2,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_LANES-1:0]          ev_valid,
  input  logic [N_LANES*CHAN_W-1:0]   ev_chan,
  input  logic [N_LANES-1:0]          ev_last,
  input  logic [N_LANES-1:0]          ev_err,
  input  logic [N_LANES*UPTR_W-1:0]   ev_uptr,
  input  logic                        cfg_we,
  input  logic [CHAN_W-1:0]           cfg_chan,
  input  logic [QSEL_W-1:0]           cfg_qsel,
  input  logic                        cfg_stream,
  output logic                        qw_valid,
  output logic [QSEL_W-1:0]           qw_qsel,
  output logic [QIDX_W-1:0]           qw_idx,
  output logic                        qw_phase,
  output logic                        qw_err,
  output logic                        qw_done,
  output logic                        qw_eop,
  output logic [CHAN_W-1:0]           qw_chan,
  output logic [UPTR_W-1:0]           qw_uptr
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  evt_t lane_evt [N_LANES];
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign lane_evt[g].chan = ev_chan[g*CHAN_W +: CHAN_W];
    assign lane_evt[g].last = ev_last[g];
    assign lane_evt[g].err  = ev_err[g];
    assign lane_evt[g].uptr = ev_uptr[g*UPTR_W +: UPTR_W];
  end

  logic head_vld;
  evt_t head_evt;

  ssq_evt_fifo #(.N_LANES(N_LANES), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (ev_valid),
    .in_evt    (lane_evt),
    .pop       (head_vld),
    .out_valid (head_vld),
    .out_evt   (head_evt)
  );

  logic              t_emit, t_stream, t_err, t_done, t_eop;
  logic [QSEL_W-1:0] t_qsel;
  logic [UPTR_W-1:0] t_uptr;

  ssq_chan_table u_tab (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cfg_we      (cfg_we),
    .cfg_chan    (cfg_chan),
    .cfg_qsel    (cfg_qsel),
    .cfg_stream  (cfg_stream),
    .in_valid    (head_vld),
    .in_evt      (head_evt),
    .emit        (t_emit),
    .emit_stream (t_stream),
    .emit_qsel   (t_qsel),
    .emit_uptr   (t_uptr),
    .emit_err    (t_err),
    .emit_done   (t_done),
    .emit_eop    (t_eop)
  );

  logic [QIDX_W-1:0] p_idx;
  logic              p_phase;

  ssq_qptr u_qptr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (t_emit),
    .wr_qsel   (t_qsel),
    .cur_idx   (p_idx),
    .cur_phase (p_phase)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) qw_valid <= 1'b0;
    else            qw_valid <= t_emit;
  end

  always_ff @(posedge clk) begin
    if (t_emit) begin
      qw_qsel  <= t_qsel;
      qw_idx   <= p_idx;
      qw_phase <= p_phase;
      qw_err   <= t_err;
      qw_done  <= t_done;
      qw_eop   <= t_eop;
      qw_chan  <= head_evt.chan;
      qw_uptr  <= t_uptr;
    end
  end

  // R7
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    qw_valid |-> $onehot({qw_err, qw_done}));

  // R2
  msg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (head_vld && !head_evt.last && !head_evt.err && !t_stream) |=> !qw_valid);
endmodule

// File: tb/ssq_reporter_bench.sv
module ssq_reporter_bench;
  import ssq_pkg::*;

  localparam int QSZ = 1 << QIDX_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        ev_valid;
  logic [7:0]        ev_chan;
  logic [1:0]        ev_last, ev_err;
  logic [31:0]       ev_uptr;
  logic              cfg_we, cfg_stream;
  logic [3:0]        cfg_chan;
  logic [4:0]        cfg_qsel;
  logic              qw_valid, qw_phase, qw_err, qw_done, qw_eop;
  logic [4:0]        qw_qsel;
  logic [1:0]        qw_idx;
  logic [3:0]        qw_chan;
  logic [15:0]       qw_uptr;

  always #2 clk = ~clk;

  ssq_reporter u_ssq_reporter (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_chan(ev_chan),
    .ev_last(ev_last), .ev_err(ev_err), .ev_uptr(ev_uptr),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_qsel(cfg_qsel),
    .cfg_stream(cfg_stream), .qw_valid(qw_valid), .qw_qsel(qw_qsel),
    .qw_idx(qw_idx), .qw_phase(qw_phase), .qw_err(qw_err),
    .qw_done(qw_done), .qw_eop(qw_eop), .qw_chan(qw_chan), .qw_uptr(qw_uptr)
  );

  int vectors = 0;
  int fails   = 0;
  bit done_run = 0;

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  evt_t        mq[$];
  int          m_qsel [16];
  bit          m_strm [16];
  bit          m_open [16];
  int          m_first[16];
  int          m_idx  [32];
  bit          m_ph   [32];
  bit          x_valid;
  int          x_qsel, x_idx, x_ph, x_err, x_done, x_eop, x_chan, x_uptr;

  initial begin
    for (int i = 0; i < 16; i++) begin m_qsel[i] = 0; m_strm[i] = 0; m_open[i] = 0; m_first[i] = 0; end
    for (int i = 0; i < 32; i++) begin m_idx[i] = 0; m_ph[i] = 1; end
    x_valid = 0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      x_valid = 0;
      if (mq.size() > 0) begin
        evt_t e;
        int c, q, p;
        e = mq.pop_front();
        c = int'(e.chan);
        if (!m_open[c]) m_first[c] = int'(e.uptr);
        p = m_first[c];
        m_open[c] = !(e.last || e.err);
        if (m_strm[c] || e.last || e.err) begin
          q = m_qsel[c];
          x_valid = 1;
          x_qsel  = q;
          x_idx   = m_idx[q];
          x_ph    = int'(m_ph[q]);
          x_chan  = c;
          x_err   = int'(e.err);
          x_done  = int'(!e.err);
          x_uptr  = m_strm[c] ? int'(e.uptr) : p;
          x_eop   = e.err ? 0 : (m_strm[c] ? int'(e.last) : 1);
          m_idx[q] = (m_idx[q] + 1) % QSZ;
          if (m_idx[q] == 0) m_ph[q] = !m_ph[q];
        end
      end
      for (int l = 0; l < 2; l++) begin
        if (ev_valid[l]) begin
          evt_t n;
          n.chan = ev_chan[l*4 +: 4];
          n.last = ev_last[l];
          n.err  = ev_err[l];
          n.uptr = ev_uptr[l*16 +: 16];
          mq.push_back(n);
        end
      end
      if (cfg_we) begin
        m_qsel[cfg_chan] = int'(cfg_qsel);
        m_strm[cfg_chan] = cfg_stream;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R10 valid low in reset", int'(qw_valid), 0);
    end else if (!done_run) begin
      check("R2 R3 R6 R9 write strobe", int'(qw_valid), int'(x_valid));
      if (qw_valid && x_valid) begin
        check("R1 queue select", int'(qw_qsel), x_qsel);
        check("R8 R10 slot index", int'(qw_idx), x_idx);
        check("R8 R10 phase", int'(qw_phase), x_ph);
        check("R4 user pointer", int'(qw_uptr), x_uptr);
        check("R5 channel", int'(qw_chan), x_chan);
        check("R6 R7 error flag", int'(qw_err), x_err);
        check("R7 done flag", int'(qw_done), x_done);
        check("R3 R7 eop flag", int'(qw_eop), x_eop);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(input int ch, input int q, input bit s);
    cfg_we = 1; cfg_chan = 4'(ch); cfg_qsel = 5'(q); cfg_stream = s;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ev2(input bit v0, input int c0, input bit l0, input bit e0, input int u0,
                     input bit v1, input int c1, input bit l1, input bit e1, input int u1);
    ev_valid = {v1, v0};
    ev_chan  = {4'(c1), 4'(c0)};
    ev_last  = {l1, l0};
    ev_err   = {e1, e0};
    ev_uptr  = {16'(u1), 16'(u0)};
    @(negedge clk);
    ev_valid = '0;
  endtask

  task automatic ev(input int c, input bit l, input bit e, input int u);
    ev2(1, c, l, e, u, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 0; ev_valid = '0; ev_chan = '0; ev_last = '0; ev_err = '0; ev_uptr = '0;
    cfg_we = 0; cfg_chan = '0; cfg_qsel = '0; cfg_stream = 0;
    idle(4);
    rst_n = 1;
    idle(4);
    cfg(1, 3, 0);
    cfg(2, 31, 1);
    cfg(5, 3, 1);
    // R2 R4: three-buffer PDU in message mode reports once with first pointer
    ev(1, 0, 0, 16'hA001); ev(1, 0, 0, 16'hA002); ev(1, 1, 0, 16'hA003);
    idle(3);
    // R3: streaming buffers each reported
    ev(2, 0, 0, 16'hB001); ev(2, 0, 0, 16'hB002); ev(2, 1, 0, 16'hB003);
    idle(3);
    // R9: two lanes in one cycle, lane 0 first
    ev2(1, 1, 0, 0, 16'hC001, 1, 2, 1, 0, 16'hD001);
    ev2(1, 1, 1, 0, 16'hC002, 1, 5, 1, 0, 16'hE001);
    idle(5);
    // R6: error mid-PDU, then a fresh PDU
    ev(1, 0, 0, 16'hF001); ev(1, 0, 1, 16'hF002); ev(1, 1, 0, 16'h6001);
    idle(3);
    ev(2, 0, 1, 16'h7001);
    idle(3);
    // R10: unconfigured channel lands in queue 0, message mode
    ev(7, 0, 0, 16'h8001); ev(7, 1, 0, 16'h8002);
    idle(3);
    // R8: wrap queue 3 several times
    for (int i = 0; i < 10; i++) ev(5, i[0], 0, 16'h9000 + i);
    idle(4);
    // R1: remap mid-run
    cfg(1, 17, 1);
    ev(1, 0, 0, 16'h1111); ev(1, 1, 0, 16'h2222);
    idle(3);
    // mixed traffic with FIFO kept from overflow
    for (int i = 0; i < 300; i++) begin
      if (mq.size() > 4) idle(1);
      else ev2($urandom_range(1, 0) == 1, int'($urandom_range(15, 0)), $urandom_range(2, 0) == 0,
               $urandom_range(9, 0) == 0, int'($urandom_range(65535, 0)),
               $urandom_range(1, 0) == 1, int'($urandom_range(15, 0)), $urandom_range(2, 0) == 0,
               $urandom_range(9, 0) == 0, int'($urandom_range(65535, 0)));
      if (i == 150) cfg(int'($urandom_range(15, 0)), int'($urandom_range(31, 0)), $urandom_range(1, 0) == 1);
    end
    idle(20);
    done_run = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule